// File: doc/BRIEF.md
# Guarded Write Sequencer with Busy Polling

This block sits behind the chip-select, serial-clock and serial-data pins of a small word-organised non-volatile store. It takes in the write-type instructions: single-word program, single-word erase, fill-all and clear-all. It also takes the enable and disable instructions that set and clear a program-enable latch. All inputs are synchronous to the system clock. A rising edge of the serial clock is found by comparing it with its value one cycle earlier.

A write-type instruction is carried out only when three conditions hold. Chip select must drop after the instruction. The program-enable latch must be set. The number of serial clock pulses, counted from the start bit, must equal exactly what that instruction needs. Once accepted, a self-timed program interval of `PROG_CYCLES` system clocks begins. Serial input is ignored for its whole length. A host that raises chip select during or after the interval sees busy (low) or ready (high) on the data output. From ready, a start bit ends the poll and begins a new instruction on the spot. A digital low-supply flag cancels any pending instruction and clears the enable latch.

The controller moves through six states. STANDBY: chip select low. HUNT: waiting for the start bit, with dummy clocks ignored. SHIFT: instruction bits arriving. BUSY: program interval. DONE: interval over, no poll yet. READY: poll showing ready.

The transitions are:
- STANDBY→HUNT when chip select rises.
- HUNT→STANDBY when chip select falls.
- HUNT→SHIFT on a start bit.
- SHIFT→BUSY when chip select falls and the instruction is accepted.
- SHIFT→STANDBY when chip select falls and the instruction is rejected.
- BUSY→READY when the interval ends with chip select high.
- BUSY→DONE when the interval ends with chip select low.
- DONE→READY when chip select rises.
- READY→STANDBY when chip select falls.
- READY→SHIFT on a start bit.

Top module: `guarded_write_seq`

## Requirements
- R1: No word of the array changes while chip select is still high after an instruction. A valid write-type instruction is committed only after chip select falls.
- R2: Pulses are counted from the start bit, which is pulse 1. The single-word program and the fill-all instruction need exactly 3+ADDR_W+DATA_W pulses (29 by default). The single-word erase and the clear-all instruction need exactly 3+ADDR_W pulses (13 by default). Any other count leaves the array unchanged.
- R3: The program-enable latch is cleared by reset. A write-type instruction has no effect while the latch is clear. An enable or disable instruction takes effect when chip select falls, provided at least 3+ADDR_W pulses were received.
- R4: Bit positions after the start bit are, in order: a 2-bit opcode, ADDR_W address bits (MSB first) and then DATA_W data bits (MSB first).
  - Opcode 01 programs a single word. Opcode 11 erases a single word to all ones.
  - Opcode 00 selects a sub-command by the top two address bits: 01 fill-all, 10 clear-all, 11 enable, 00 disable.
  - Fill-all stores the data in every word whatever the remaining address bits. Clear-all sets every word to all ones.
- R5: Serial clock, serial data and chip select activity during the program interval of PROG_CYCLES clocks has no effect on the array.
- R6: When chip select is high, `do_oe` is 1 with `do_out` 0 during the program interval, and `do_oe` is 1 with `do_out` 1 once the interval is over. `do_oe` is 0 whenever chip select is low.
- R7: While ready is shown, a serial clock rise with data high is taken as a start bit. `do_oe` drops to 0 at once and the following bits form a new instruction.
- R8: Asserting `low_supply` clears the program-enable latch at once. A write-type instruction in flight, or one sent afterwards, is cancelled. A new enable instruction restores writing.
- R9: Serial clock rises with data low before the start bit are not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset (array contents are kept) |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock, sampled by clk |
| di | input | 1 | Serial data in |
| low_supply | input | 1 | Low-supply flag |
| rd_addr | input | ADDR_W | Array read address |
| do_oe | output | 1 | Data output enable (0 = high impedance) |
| do_out | output | 1 | Data output level when enabled |
| rd_data | output | DATA_W | Array word at rd_addr |

## Verification
The hardest situation to reach is a start bit arriving while ready is shown. The poll has to be carried through the whole program interval with chip select held high. The new instruction must then begin without chip select ever falling. The bench polls until ready appears and keeps chip select up. It then clocks a start bit followed by a full program frame, and checks both the immediate release of the output and the commit of the new word.

Serial traffic sent during an interval must be shown to have no effect. For this the bench issues a second program frame while the first is still busy, then checks that the word holds the first value.

// File: rtl/gws_pkg.sv
package gws_pkg;
    typedef enum logic [2:0] {
        ST_STANDBY,
        ST_HUNT,
        ST_SHIFT,
        ST_BUSY,
        ST_DONE,
        ST_READY
    } gws_state_e;

    localparam logic [1:0] OP_SPECIAL = 2'b00;
    localparam logic [1:0] OP_PROGRAM = 2'b01;
    localparam logic [1:0] OP_ERASE   = 2'b11;

    localparam logic [1:0] SUB_DISABLE = 2'b00;
    localparam logic [1:0] SUB_FILL    = 2'b01;
    localparam logic [1:0] SUB_CLEAR   = 2'b10;
    localparam logic [1:0] SUB_ENABLE  = 2'b11;
endpackage

// File: rtl/gws_frame_capture.sv
module gws_frame_capture #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              shift_en,
    input  logic              di,
    output logic [CNT_W-1:0]  pulse_cnt,
    output logic [1:0]        op,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data
);
    localparam int CNT_ADDR = 3 + ADDR_W;
    localparam int CNT_DATA = CNT_ADDR + DATA_W;
    localparam logic [CNT_W-1:0] K_OPEND = CNT_W'(3);
    localparam logic [CNT_W-1:0] K_ADDR  = CNT_W'(CNT_ADDR);
    localparam logic [CNT_W-1:0] K_DATA  = CNT_W'(CNT_DATA);
    localparam logic [CNT_W-1:0] K_SAT   = CNT_W'(CNT_DATA + 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_cnt <= '0;
            op        <= '0;
            addr      <= '0;
            data      <= '0;
        end else if (clear) begin
            pulse_cnt <= CNT_W'(1);
            op        <= '0;
            addr      <= '0;
            data      <= '0;
        end else if (shift_en) begin
            if (pulse_cnt != K_SAT)
                pulse_cnt <= pulse_cnt + 1'b1;
            if (pulse_cnt < K_OPEND)
                op <= {op[0], di};
            else if (pulse_cnt < K_ADDR)
                addr <= {addr[ADDR_W-2:0], di};
            else if (pulse_cnt < K_DATA)
                data <= {data[DATA_W-2:0], di};
        end
    end
endmodule

// File: rtl/gws_prog_timer.sv
module gws_prog_timer #(
    parameter int PROG_CYCLES = 400000,
    parameter int ADDR_W      = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              run,
    output logic              done,
    output logic              first,
    output logic              sweep_live,
    output logic [ADDR_W-1:0] sweep_idx
);
    localparam int WORDS = 1 << ADDR_W;
    localparam int TW0   = $clog2(PROG_CYCLES + 1);
    localparam int TMR_W = (TW0 > ADDR_W + 1) ? TW0 : ADDR_W + 1;
    localparam logic [TMR_W-1:0] K_LAST  = TMR_W'(PROG_CYCLES - 1);
    localparam logic [TMR_W-1:0] K_WORDS = TMR_W'(WORDS);

    logic [TMR_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run <= 1'b0;
            cnt <= '0;
        end else if (start) begin
            run <= 1'b1;
            cnt <= '0;
        end else if (run) begin
            if (cnt == K_LAST)
                run <= 1'b0;
            else
                cnt <= cnt + 1'b1;
        end
    end

    assign done       = run && (cnt == K_LAST);
    assign first      = run && (cnt == '0);
    assign sweep_live = run && (cnt < K_WORDS);
    assign sweep_idx  = cnt[ADDR_W-1:0];
endmodule

// File: rtl/gws_word_array.sv
module gws_word_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] wa,
    input  logic [DATA_W-1:0] wd,
    input  logic [ADDR_W-1:0] ra,
    output logic [DATA_W-1:0] rd
);
    localparam int WORDS = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we)
            mem[wa] <= wd;
    end

    assign rd = mem[ra];
endmodule

// File: rtl/guarded_write_seq.sv
module guarded_write_seq
    import gws_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int DATA_W      = 16,
    parameter int PROG_CYCLES = 400000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              sk,
    input  logic              di,
    input  logic              low_supply,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              do_oe,
    output logic              do_out,
    output logic [DATA_W-1:0] rd_data
);
    localparam int CNT_ADDR = 3 + ADDR_W;
    localparam int CNT_DATA = CNT_ADDR + DATA_W;
    localparam int CNT_W    = $clog2(CNT_DATA + 2);
    localparam logic [CNT_W-1:0] K_ADDR = CNT_W'(CNT_ADDR);
    localparam logic [CNT_W-1:0] K_DATA = CNT_W'(CNT_DATA);

    gws_state_e        state_q, state_d;
    logic              sk_q, sk_rise, start_bit, shift_done, launch;
    logic              pe_q, bulk_q;
    logic [DATA_W-1:0] val_q;
    logic [ADDR_W-1:0] waddr_q;
    logic [CNT_W-1:0]  pulse_cnt;
    logic [1:0]        cap_op, mode;
    logic [ADDR_W-1:0] cap_addr, sweep_idx, arr_wa;
    logic [DATA_W-1:0] cap_data;
    logic              tmr_run, tmr_done, tmr_first, sweep_live, arr_we;
    logic              is_prog, is_erase, is_fill, is_clear, is_en, is_dis, cnt_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sk_q <= 1'b0;
        else        sk_q <= sk;
    end
    assign sk_rise = sk && !sk_q;
    assign start_bit = cs && sk_rise && di &&
                       (state_q == ST_HUNT || state_q == ST_READY);

    gws_frame_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .clear(start_bit),
        .shift_en(state_q == ST_SHIFT && cs && sk_rise), .di(di),
        .pulse_cnt(pulse_cnt), .op(cap_op), .addr(cap_addr), .data(cap_data)
    );

    // instruction decode
    assign mode     = cap_addr[ADDR_W-1 -: 2];
    assign is_prog  = (cap_op == OP_PROGRAM);
    assign is_erase = (cap_op == OP_ERASE);
    assign is_fill  = (cap_op == OP_SPECIAL) && (mode == SUB_FILL);
    assign is_clear = (cap_op == OP_SPECIAL) && (mode == SUB_CLEAR);
    assign is_en    = (cap_op == OP_SPECIAL) && (mode == SUB_ENABLE);
    assign is_dis   = (cap_op == OP_SPECIAL) && (mode == SUB_DISABLE);
    assign cnt_ok   = ((is_prog || is_fill) && pulse_cnt == K_DATA) ||
                      ((is_erase || is_clear) && pulse_cnt == K_ADDR);

    assign shift_done = (state_q == ST_SHIFT) && !cs;
    assign launch     = shift_done && pe_q && !low_supply && cnt_ok;

    // program-enable latch and accepted-instruction record
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pe_q    <= 1'b0;
            bulk_q  <= 1'b0;
            val_q   <= '0;
            waddr_q <= '0;
        end else begin
            if (low_supply)
                pe_q <= 1'b0;
            else if (shift_done && pulse_cnt >= K_ADDR) begin
                if (is_en)  pe_q <= 1'b1;
                if (is_dis) pe_q <= 1'b0;
            end
            if (launch) begin
                bulk_q  <= is_fill || is_clear;
                val_q   <= (is_erase || is_clear) ? '1 : cap_data;
                waddr_q <= cap_addr;
            end
        end
    end

    gws_prog_timer #(.PROG_CYCLES(PROG_CYCLES), .ADDR_W(ADDR_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start(launch), .run(tmr_run), .done(tmr_done),
        .first(tmr_first), .sweep_live(sweep_live), .sweep_idx(sweep_idx)
    );

    assign arr_we = tmr_run && (bulk_q ? sweep_live : tmr_first);
    assign arr_wa = bulk_q ? sweep_idx : waddr_q;

    gws_word_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
        .clk(clk), .we(arr_we), .wa(arr_wa), .wd(val_q), .ra(rd_addr), .rd(rd_data)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STANDBY;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STANDBY: if (cs) state_d = ST_HUNT;
            ST_HUNT: begin
                if (!cs)            state_d = ST_STANDBY;
                else if (start_bit) state_d = ST_SHIFT;
            end
            ST_SHIFT:   if (!cs) state_d = launch ? ST_BUSY : ST_STANDBY;
            ST_BUSY:    if (tmr_done) state_d = cs ? ST_READY : ST_DONE;
            ST_DONE:    if (cs) state_d = ST_READY;
            ST_READY: begin
                if (!cs)            state_d = ST_STANDBY;
                else if (start_bit) state_d = ST_SHIFT;
            end
            default:    state_d = ST_STANDBY;
        endcase
    end

    // outputs
    always_comb begin
        do_oe  = 1'b0;
        do_out = 1'b0;
        unique case (state_q)
            ST_BUSY:  do_oe = cs;
            ST_READY: begin
                do_oe  = cs;
                do_out = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/gws_checker.sv
module gws_checker
    import gws_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs,
    input gws_state_e       state,
    input logic             arr_we,
    input logic             pe,
    input logic             low_supply,
    input logic [CNT_W-1:0] pulse_cnt,
    input logic             tmr_run,
    input logic             do_oe,
    input logic             do_out
);
    localparam logic [CNT_W-1:0] K_ADDR = CNT_W'(3 + ADDR_W);
    localparam logic [CNT_W-1:0] K_DATA = CNT_W'(3 + ADDR_W + DATA_W);

    AST_WE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> state == ST_BUSY); // R1
    AST_EXACT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmr_run) |-> $past(pulse_cnt == K_ADDR || pulse_cnt == K_DATA)); // R2
    AST_ENABLED_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmr_run) |-> $past(pe)); // R3
    AST_BUSY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY && $past(state == ST_BUSY)) |-> $stable(pulse_cnt)); // R5
    AST_BUSY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_run && cs) |-> (do_oe && !do_out)); // R6
    AST_LOWSUP_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
        low_supply |=> !pe); // R8
endmodule

bind guarded_write_seq gws_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs(cs), .state(state_q), .arr_we(arr_we), .pe(pe_q),
    .low_supply(low_supply), .pulse_cnt(pulse_cnt), .tmr_run(tmr_run),
    .do_oe(do_oe), .do_out(do_out)
);

// File: tb/guarded_write_seq_tb.sv
`timescale 1ns/1ps
module guarded_write_seq_tb;
    localparam int AW = 10;
    localparam int DW = 16;
    localparam int PC = 1200;

    logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0, low_supply = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic do_oe, do_out;
    logic [DW-1:0] rd_data;
    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    guarded_write_seq #(.ADDR_W(AW), .DATA_W(DW), .PROG_CYCLES(PC)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .low_supply(low_supply),
        .rd_addr(rd_addr), .do_oe(do_oe), .do_out(do_out), .rd_data(rd_data)
    );

    task automatic tk();
        @(posedge clk); #1;
    endtask

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic chk_word(string req, int a, logic [15:0] exp);
        rd_addr = AW'(a);
        @(negedge clk);
        chk(req, $sformatf("word %0d", a), 32'(rd_data), 32'(exp));
    endtask

    task automatic sk_bit(logic b);
        tk(); di = b; sk = 1'b0;
        tk(); sk = 1'b1;
        tk(); sk = 1'b0; di = 1'b0;
    endtask

    task automatic send_bits(logic [27:0] bits, int from, int npulses);
        for (int i = from; i < npulses; i++)
            sk_bit(i <= 28 ? bits[28-i] : 1'b0);
    endtask

    task automatic frame(logic [1:0] op, logic [9:0] a, logic [15:0] d, int npulses, int ndummy);
        cs = 1'b1;
        tk();
        for (int i = 0; i < ndummy; i++) sk_bit(1'b0);
        sk_bit(1'b1);
        send_bits({op, a, d}, 1, npulses);
    endtask

    task automatic cs_low();
        tk(); cs = 1'b0; tk(); tk();
    endtask

    task automatic pe_enable();
        frame(2'b00, 10'h300, 16'h0, 13, 0); cs_low();
    endtask

    task automatic pe_disable();
        frame(2'b00, 10'h000, 16'h0, 13, 0); cs_low();
    endtask

    task automatic poll(string req, bit keep);
        int w;
        cs = 1'b1;
        tk(); tk();
        @(negedge clk);
        chk(req, "busy on DO", 32'({do_oe, do_out}), 32'(2'b10));
        w = 0;
        while (!(do_oe && do_out) && w < 5000) begin
            @(negedge clk);
            w++;
        end
        chk(req, "ready on DO", 32'({do_oe, do_out}), 32'(2'b11));
        if (!keep) begin
            cs_low();
            @(negedge clk);
            chk("R6", "DO released with cs low", 32'(do_oe), 32'(0));
        end
    endtask

    task automatic t_reset_and_clear();
        @(negedge clk);
        chk("R6", "DO off after reset", 32'(do_oe), 32'(0));
        pe_enable();
        frame(2'b00, 10'h200, 16'h0, 13, 0); cs_low();
        poll("R6", 1'b0);
        chk_word("R4", 0, 16'hFFFF);
        chk_word("R4", 511, 16'hFFFF);
        chk_word("R4", 1023, 16'hFFFF);
    endtask

    task automatic t_reset_disabled();
        rst_n = 1'b0; repeat (4) tk(); rst_n = 1'b1; tk();
        frame(2'b01, 10'd7, 16'h0000, 29, 0); cs_low();
        cs = 1'b1; tk(); tk();
        @(negedge clk);
        chk("R3", "no busy when latch reset", 32'(do_oe), 32'(0));
        cs_low();
        repeat (20) tk();
        chk_word("R3", 7, 16'hFFFF);
    endtask

    task automatic t_write_exact();
        pe_enable();
        frame(2'b01, 10'd5, 16'hA5C3, 29, 0);
        repeat (4) tk();
        chk_word("R1", 5, 16'hFFFF);
        cs_low();
        poll("R6", 1'b0);
        chk_word("R1", 5, 16'hA5C3);
    endtask

    task automatic t_count_guard();
        frame(2'b01, 10'd6, 16'h1111, 30, 0); cs_low(); repeat (30) tk();
        chk_word("R2", 6, 16'hFFFF);
        frame(2'b01, 10'd6, 16'h1111, 28, 0); cs_low(); repeat (30) tk();
        chk_word("R2", 6, 16'hFFFF);
        frame(2'b11, 10'd5, 16'h0, 14, 0); cs_low(); repeat (30) tk();
        chk_word("R2", 5, 16'hA5C3);
        frame(2'b11, 10'd5, 16'h0, 12, 0); cs_low(); repeat (30) tk();
        chk_word("R2", 5, 16'hA5C3);
        frame(2'b11, 10'd5, 16'h0, 13, 0); cs_low();
        poll("R2", 1'b0);
        chk_word("R4", 5, 16'hFFFF);
    endtask

    task automatic t_disabled();
        pe_disable();
        frame(2'b01, 10'd8, 16'h1357, 29, 0); cs_low(); repeat (30) tk();
        chk_word("R3", 8, 16'hFFFF);
        pe_enable();
    endtask

    task automatic t_fill_all();
        frame(2'b00, 10'h15A, 16'h3C3C, 29, 0); cs_low();
        poll("R4", 1'b0);
        chk_word("R4", 0, 16'h3C3C);
        chk_word("R4", 346, 16'h3C3C);
        chk_word("R4", 1023, 16'h3C3C);
    endtask

    task automatic t_busy_ignored();
        frame(2'b01, 10'd12, 16'h2468, 29, 0); cs_low();
        frame(2'b01, 10'd12, 16'h9999, 29, 0); cs_low();
        poll("R5", 1'b0);
        chk_word("R5", 12, 16'h2468);
    endtask

    task automatic t_verify_start();
        frame(2'b01, 10'd20, 16'hBEEF, 29, 0); cs_low();
        poll("R7", 1'b1);
        sk_bit(1'b1);
        @(negedge clk);
        chk("R7", "DO released on start bit", 32'(do_oe), 32'(0));
        send_bits({2'b01, 10'd21, 16'h0F0F}, 1, 29);
        cs_low();
        poll("R7", 1'b0);
        chk_word("R7", 20, 16'hBEEF);
        chk_word("R7", 21, 16'h0F0F);
    endtask

    task automatic t_dummy();
        frame(2'b01, 10'd30, 16'h5A5A, 29, 3); cs_low();
        poll("R9", 1'b0);
        chk_word("R9", 30, 16'h5A5A);
    endtask

    task automatic t_low_supply();
        tk(); low_supply = 1'b1; tk(); low_supply = 1'b0;
        frame(2'b01, 10'd40, 16'h1111, 29, 0); cs_low(); repeat (30) tk();
        chk_word("R8", 40, 16'h3C3C);
        pe_enable();
        fork
            frame(2'b01, 10'd41, 16'h2222, 29, 0);
            begin repeat (30) tk(); low_supply = 1'b1; tk(); low_supply = 1'b0; end
        join
        cs_low(); repeat (30) tk();
        chk_word("R8", 41, 16'h3C3C);
        pe_enable();
        frame(2'b01, 10'd41, 16'h4242, 29, 0); cs_low();
        poll("R8", 1'b0);
        chk_word("R8", 41, 16'h4242);
    endtask

    initial begin
        repeat (4) tk();
        rst_n = 1'b1;
        tk();
        t_reset_and_clear();
        t_reset_disabled();
        t_write_exact();
        t_count_guard();
        t_disabled();
        t_fill_all();
        t_busy_ignored();
        t_verify_start();
        t_dummy();
        t_low_supply();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule